// File: doc/BRIEF.md
# Two-Wire Configuration Store Slave

This block is a slave on a two-wire serial bus (I2C-style) that serves a 256-byte configuration store to a host. A fast system clock samples the bus clock and data lines. The block finds start and stop conditions and checks each incoming slave byte against a fixed 4-bit type code followed by three strap pins. When the byte matches, the block pulls the data line low for the acknowledge.

The host can do four kinds of access. It can write bytes. It can read from the current address. It can do a random read: first a dummy write that sets the word address, then a repeated start and a read. It can read a sequence of bytes, which runs past the top address back to address 0. One address counter is shared by reads and writes. It always points one byte past the last byte that was read or written. The lower half of the store holds data set at manufacture and cannot be written. A write-protect pin blocks all writes. The block never drives the data line high. It only controls an open-drain pull-down enable.

Top module: `presence_store_slave`

## Requirements
- R1: After reset, sdaOe is low and the address counter is 0. Store byte i holds i XOR INIT_XOR.
- R2: A start (SDA falls while SCL is high) in any state abandons the current transfer and begins slave-byte matching. A stop (SDA rises while SCL is high) returns the block to idle with the line released.
- R3: In the slave byte, bits 7:4 must equal 4'b1010 and bits 3:1 must equal strapIn[2:0]. Bit 0 selects the direction: 1 means read. On a match, sdaOe is high during the 9th clock. On a mismatch there is no acknowledge, and the line is not driven again until the next start.
- R4: In a write transfer, the byte after the slave byte loads the address counter. A repeated start followed by a read then returns the byte at that address.
- R5: A read with no word address returns the byte at the counter. Each byte read or written advances the counter by one.
- R6: When the host acknowledges a read byte, the next byte follows. After address 255 comes address 0.
- R7: When the host does not acknowledge, the slave stops driving until the next start or stop. The counter is not advanced beyond the byte already sent.
- R8: Every data byte written is acknowledged. It is stored only at addresses 128 to 255. Bytes at addresses 0 to 127 keep their value.
- R9: While wpIn is high, written bytes are still acknowledged and still advance the counter, but the store is not changed.
- R10: sdaOe rises only while SCL is low, after the synchronised SCL has been seen falling.
- R11: Bytes are sent most significant bit first. sdaOe high means the line is pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level, including this block's own pull-down |
| strapIn | input | 3 | Strap bits compared against slave-byte bits 3:1 |
| wpIn | input | 1 | Write protect, high blocks all stores |
| sdaOe | output | 1 | Open-drain enable, high pulls the data line low |

## Verification
The bench keeps ADDR_W at 8 and the type code at its default. With ADDR_W at 8, a wrap past address 255 takes only a few bytes of sequential reading or writing. The bench sets INIT_XOR to 8'hC3, so the preset contents differ from the default and are not symmetric. Every expected byte therefore depends on the exact address read. The bench sets strapIn to 3'b101. This lets it test both a strap mismatch and a type-code mismatch.

// File: rtl/pstore_pkg.sv
package pstore_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] ACK_POS = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] DONE_POS = CNT_W'(BYTE_W + 1);

  typedef enum logic [2:0] {
    PH_IDLE, PH_DEV, PH_WORD, PH_DATA, PH_TX, PH_WAIT
  } phase_e;

  typedef struct packed {
    logic shiftIn;
    logic rxBit;
    logic loadAddr;
    logic writeByte;
    logic loadTx;
  } ctlStrobe_t;
endpackage

// File: rtl/pstore_datapath.sv
module pstore_datapath
  import pstore_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [7:0] INIT_XOR = 8'h5A
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobes,
  input  logic              wpIn,
  output logic [BYTE_W-1:0] rxByte,
  output logic [BYTE_W-1:0] curByte,
  output logic [BYTE_W-1:0] txByte,
  output logic [ADDR_W-1:0] curAddr
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LOCK_LIMIT = DEPTH / 2;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic              storeOk;

  assign curByte = mem[curAddr];
  assign storeOk = !wpIn && (int'(curAddr) >= LOCK_LIMIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= BYTE_W'(i) ^ INIT_XOR;
      rxByte  <= '0;
      txByte  <= '0;
      curAddr <= '0;
    end else begin
      if (strobes.shiftIn) rxByte <= {rxByte[BYTE_W-2:0], strobes.rxBit};
      if (strobes.loadAddr) curAddr <= ADDR_W'(rxByte);
      if (strobes.writeByte) begin
        if (storeOk) mem[curAddr] <= rxByte;
        curAddr <= curAddr + 1'b1;
      end
      if (strobes.loadTx) begin
        txByte  <= curByte;
        curAddr <= curAddr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pstore_control.sv
module pstore_control
  import pstore_pkg::*;
#(
  parameter logic [3:0] TYPE_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2:0]        strapIn,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [BYTE_W-1:0] curByte,
  input  logic [BYTE_W-1:0] txByte,
  output ctlStrobe_t        strobes,
  output logic              sdaOe
);
  localparam int IDX_W = $clog2(BYTE_W);

  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  logic       sclS, sdaS, sclRise, sclFall, startSeen, stopSeen;
  phase_e     phase, afterAck;
  logic [CNT_W-1:0] bitCnt;
  logic       masterAck, devMatch, rxPhase;

  assign sclS      = sclSync[1];
  assign sdaS      = sdaSync[1];
  assign sclRise   = sclS && !sclPrev;
  assign sclFall   = !sclS && sclPrev;
  assign startSeen = sclS && sclPrev && sdaPrev && !sdaS;
  assign stopSeen  = sclS && sclPrev && !sdaPrev && sdaS;
  assign devMatch  = rxByte[BYTE_W-1:1] == {TYPE_CODE, strapIn};
  assign rxPhase   = (phase == PH_DEV) || (phase == PH_WORD) || (phase == PH_DATA);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  always_comb begin
    strobes = '0;
    if (!startSeen && !stopSeen) begin
      if (rxPhase && sclRise && bitCnt < ACK_POS) begin
        strobes.shiftIn = 1'b1;
        strobes.rxBit   = sdaS;
      end
      if (sclFall && bitCnt == ACK_POS) begin
        strobes.loadAddr  = (phase == PH_WORD);
        strobes.writeByte = (phase == PH_DATA);
      end
      if (sclFall && bitCnt == DONE_POS) begin
        strobes.loadTx = (phase == PH_DEV && afterAck == PH_TX) ||
                         (phase == PH_TX && masterAck);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      afterAck  <= PH_IDLE;
      bitCnt    <= '0;
      masterAck <= 1'b0;
      sdaOe     <= 1'b0;
    end else if (startSeen) begin
      phase  <= PH_DEV;
      bitCnt <= '0;
      sdaOe  <= 1'b0;
    end else if (stopSeen) begin
      phase  <= PH_IDLE;
      bitCnt <= '0;
      sdaOe  <= 1'b0;
    end else if (rxPhase) begin
      if (sclRise && bitCnt < ACK_POS) begin
        bitCnt <= bitCnt + 1'b1;
      end else if (sclFall && bitCnt == ACK_POS) begin
        if (phase == PH_DEV && !devMatch) begin
          phase <= PH_WAIT;
        end else begin
          sdaOe    <= 1'b1;
          bitCnt   <= DONE_POS;
          afterAck <= (phase != PH_DEV) ? PH_DATA :
                      (rxByte[0] ? PH_TX : PH_WORD);
        end
      end else if (sclFall && bitCnt == DONE_POS) begin
        bitCnt <= '0;
        phase  <= afterAck;
        sdaOe  <= (afterAck == PH_TX) ? !curByte[BYTE_W-1] : 1'b0;
      end
    end else if (phase == PH_TX) begin
      if (sclRise && bitCnt < DONE_POS) begin
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt == ACK_POS) masterAck <= !sdaS;
      end else if (sclFall) begin
        if (bitCnt < ACK_POS) begin
          sdaOe <= !txByte[IDX_W'(BYTE_W - 1 - int'(bitCnt))];
        end else if (bitCnt == ACK_POS) begin
          sdaOe <= 1'b0;
        end else if (masterAck) begin
          sdaOe  <= !curByte[BYTE_W-1];
          bitCnt <= '0;
        end else begin
          sdaOe <= 1'b0;
          phase <= PH_WAIT;
        end
      end
    end
  end
endmodule

// File: rtl/presence_store_slave.sv
module presence_store_slave
  import pstore_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [3:0] TYPE_CODE = 4'b1010,
  parameter logic [7:0] INIT_XOR = 8'h5A
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strapIn,
  input  logic       wpIn,
  output logic       sdaOe
);
  ctlStrobe_t        strobes;
  logic [BYTE_W-1:0] rxByte, curByte, txByte;
  logic [ADDR_W-1:0] curAddr;

  pstore_control #(.TYPE_CODE(TYPE_CODE)) ctl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strapIn(strapIn),
    .rxByte(rxByte), .curByte(curByte), .txByte(txByte),
    .strobes(strobes), .sdaOe(sdaOe)
  );

  pstore_datapath #(.ADDR_W(ADDR_W), .INIT_XOR(INIT_XOR)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wpIn(wpIn),
    .rxByte(rxByte), .curByte(curByte), .txByte(txByte), .curAddr(curAddr)
  );
endmodule

// File: rtl/presence_store_checker.sv
module presence_store_checker
  import pstore_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaOe,
  input ctlStrobe_t        strobes,
  input logic [ADDR_W-1:0] curAddr,
  input logic [BYTE_W-1:0] rxByte
);
  a_r4_word_load: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadAddr |=> curAddr == ADDR_W'($past(rxByte)));

  a_r5_read_step: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadTx |=> curAddr == ADDR_W'($past(curAddr) + 1'b1));

  a_r9_write_step: assert property (@(posedge clk) disable iff (!rstN)
    strobes.writeByte |=> curAddr == ADDR_W'($past(curAddr) + 1'b1));

  a_r2_single_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.loadAddr, strobes.writeByte, strobes.loadTx}));

  a_r10_oe_rise_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclIn);
endmodule

bind presence_store_slave presence_store_checker #(.ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .strobes(strobes), .curAddr(curAddr), .rxByte(rxByte)
);

// File: tb/presence_store_slave_test.sv
module presence_store_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam logic [7:0] XOR_KEY = 8'hC3;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};
  // kind: 0 write one byte, 1 random read, 2 current-address read
  localparam logic [17:0] VEC [10] = '{
    {2'd2, 8'h00, 8'h00}, {2'd1, 8'h10, 8'h00}, {2'd2, 8'h00, 8'h00},
    {2'd0, 8'h05, 8'hEE}, {2'd1, 8'h05, 8'h00}, {2'd0, 8'h90, 8'h3C},
    {2'd2, 8'h00, 8'h00}, {2'd1, 8'h90, 8'h00}, {2'd0, 8'hFF, 8'h77},
    {2'd2, 8'h00, 8'h00}
  };

  logic clk = 0, rstN = 0, sclM = 1, sdaM = 1, wp = 0;
  logic sdaOe;
  wire  sdaBus = sdaM & ~sdaOe;
  int   vecCount = 0, missCount = 0, badRise = 0;
  logic [7:0] model [256];
  logic [7:0] ptr;
  logic prevOe = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  presence_store_slave #(.INIT_XOR(XOR_KEY)) uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .strapIn(STRAP), .wpIn(wp), .sdaOe(sdaOe)
  );

  always @(posedge clk) begin
    if (rstN && sdaOe && !prevOe && sclM) badRise <= badRise + 1;
    prevOe <= sdaOe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    vecCount++;
    if (act != exp) begin
      missCount++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic startCond();
    sdaM = 1; tick(Q); sclM = 1; tick(Q); sdaM = 0; tick(Q); sclM = 0; tick(Q);
  endtask

  task automatic stopCond();
    sdaM = 0; tick(Q); sclM = 1; tick(Q); sdaM = 1; tick(Q);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; tick(Q); sclM = 1; tick(2 * Q); sclM = 0; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1; tick(Q); sclM = 1; tick(Q); acked = !sdaBus; tick(Q); sclM = 0; tick(Q);
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1; tick(Q); sclM = 1; tick(Q); b[i] = sdaBus; tick(Q); sclM = 0; tick(Q);
    end
    sdaM = !ackIt; tick(Q); sclM = 1; tick(2 * Q); sclM = 0; tick(Q);
  endtask

  task automatic setWord(input logic [7:0] a, input string tag);
    logic ak;
    startCond();
    sendByte(DEV_W, ak); check({tag, " slave ack"}, ak, 1);
    sendByte(a, ak);     check({tag, " word ack"}, ak, 1);
    ptr = a;
  endtask

  task automatic readOne(input string tag);
    logic ak; logic [7:0] d;
    startCond();
    sendByte(DEV_R, ak); check({tag, " read ack"}, ak, 1);
    recvByte(1'b0, d);   check({tag, " data"}, d, model[ptr]);
    stopCond();
    ptr = ptr + 1;
  endtask

  task automatic writeOne(input logic [7:0] a, input logic [7:0] v, input string tag);
    logic ak;
    setWord(a, tag);
    sendByte(v, ak); check({tag, " data ack"}, ak, 1);
    stopCond();
    if (a >= 8'h80 && !wp) model[a] = v;
    ptr = a + 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    missCount++; vecCount++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    logic ak; logic [7:0] d;
    for (int i = 0; i < 256; i++) model[i] = 8'(i) ^ XOR_KEY;
    ptr = 0;
    tick(5); rstN = 1; tick(5);
    check("R1 sdaOe after reset", sdaOe, 0);

    // Table: R1 preset/counter, R4 random read, R5 current read, R8 stores
    for (int v = 0; v < 10; v++) begin
      case (VEC[v][17:16])
        2'd0: writeOne(VEC[v][15:8], VEC[v][7:0], "R8 write");
        2'd1: begin setWord(VEC[v][15:8], "R4 random"); readOne("R4 random"); end
        default: readOne("R5 R11 current");
      endcase
    end

    // R3: strap mismatch, then no drive at all
    startCond();
    sendByte({4'b1010, 3'b011, 1'b1}, ak); check("R3 strap mismatch ack", ak, 0);
    recvByte(1'b0, d); check("R3 silent after mismatch", d, 8'hFF);
    stopCond();
    startCond();
    sendByte({4'b1011, STRAP, 1'b1}, ak); check("R3 type mismatch ack", ak, 0);
    stopCond();
    check("R2 line released after stop", sdaOe, 0);

    // R6: sequential read across the wrap
    setWord(8'hFD, "R6 seq");
    startCond();
    sendByte(DEV_R, ak); check("R6 read ack", ak, 1);
    for (int k = 0; k < 5; k++) begin
      recvByte(k != 4, d);
      check("R6 sequential data", d, model[8'(8'hFD + k)]);
    end
    stopCond();
    ptr = 8'h02;

    // R7: after master NACK the slave stays silent and the counter holds
    startCond();
    sendByte(DEV_R, ak); check("R7 read ack", ak, 1);
    recvByte(1'b0, d);   check("R7 data before nack", d, model[ptr]);
    recvByte(1'b0, d);   check("R7 silent after nack", d, 8'hFF);
    stopCond();
    ptr = ptr + 1;
    readOne("R7 counter after nack");

    // R9: write protect
    wp = 1;
    writeOne(8'hA0, 8'h11, "R9 protected write");
    wp = 0;
    readOne("R9 counter advances");
    setWord(8'hA0, "R9 readback"); readOne("R9 unchanged");

    // R8: multi-byte write across the wrap into the locked half
    setWord(8'hFE, "R8 burst");
    sendByte(8'h21, ak); check("R8 burst ack 0", ak, 1);
    sendByte(8'h22, ak); check("R8 burst ack 1", ak, 1);
    sendByte(8'h23, ak); check("R8 burst ack locked", ak, 1);
    stopCond();
    model[8'hFE] = 8'h21; model[8'hFF] = 8'h22;
    ptr = 8'h01;
    readOne("R8 counter after burst");
    setWord(8'hFE, "R8 burst readback");
    startCond();
    sendByte(DEV_R, ak);
    recvByte(1'b1, d); check("R8 stored FE", d, 8'h21);
    recvByte(1'b1, d); check("R8 stored FF", d, 8'h22);
    recvByte(1'b0, d); check("R8 locked 00", d, model[0]);
    stopCond();
    ptr = 8'h01;

    // R2: start in the middle of a byte aborts the transfer
    setWord(8'h85, "R2 abort");
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    readOne("R2 read after abort");
    setWord(8'h85, "R2 abort check"); readOne("R2 no partial store");

    check("R10 sdaOe rises only with SCL low", badRise, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule